// File: doc/BRIEF.md
# Low-PAPR Candidate Selector for OFDM Symbols

This block takes one 64-sample OFDM symbol in the time domain, straight from an IFFT output. It forms three extra phase-rotated versions of that symbol without running another IFFT. A rotation pattern of period 4 over the subcarriers is the same, in the time domain, as a weighted sum of four copies of the symbol spaced a quarter-symbol apart. Each weight is a sign, a swap of real and imaginary parts, or a halving, so each candidate sample needs only additions.

The block runs in three phases:

1. **Load.** It stores the symbol.
2. **Evaluate.** It takes one pass over the stored samples to find the peak instantaneous power of each of the four candidates. Rotation keeps the symbol energy, so all candidates have the same average power. The lowest peak therefore marks the lowest PAPR.
3. **Replay.** It regenerates the winning candidate and streams it out under a ready/valid handshake. A 2-bit index names the chosen rotation, so that a receiver can undo it.

Top module: `slm_selector`

## Requirements
- R1: `in_ready` is high only in the load phase, and exactly 64 accepted samples (`in_valid && in_ready`) complete the load. `in_ready` and `out_valid` are never high together.
- R2: Candidate 0 (index 0, no rotation) is the stored sample itself, sign-extended to the output width.
- R3: Candidate 1 (pattern 1, j, 1, j) at position n is floor(((1+j)·x[n] + (1−j)·x[(n−32) mod 64]) / 2), applied to each of the real and imaginary parts.
- R4: Candidate 2 (pattern 1, j, 1, −j) at position n is floor((x[n] − x[(n−16) mod 64] + x[(n−32) mod 64] + x[(n−48) mod 64]) / 2), applied to each part.
- R5: Candidate 3 (pattern 1, j, −1, j) at position n is floor((j·x[n] + x[(n−16) mod 64] − j·x[(n−32) mod 64] + x[(n−48) mod 64]) / 2), applied to each part.
- R6: The block streams the candidate with the smallest maximum of re² + im² over its 64 samples. When peaks are equal, the lower index wins.
- R7: `out_side` carries the winning index in binary and holds for the whole symbol. `out_first` flags output sample 0 and `out_last` flags sample 63. Samples leave in order n = 0..63.
- R8: `out_valid` first rises exactly 65 clock cycles after the cycle in which the 64th input sample is accepted.
- R9: While `out_valid` is high and `out_ready` is low, the output sample, its flags and `out_side` hold. No sample is skipped or repeated.
- R10: In the cycle after the last output sample is accepted, `in_ready` is high and `out_valid` is low. The next symbol is handled independently of the one before.
- R11: While `rst` is high and in the cycle after, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts input samples |
| in_re | input | DW (12) | Input sample, real part, signed |
| in_im | input | DW (12) | Input sample, imaginary part, signed |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts output sample |
| out_re | output | DW+2 (14) | Output sample, real part, signed |
| out_im | output | DW+2 (14) | Output sample, imaginary part, signed |
| out_side | output | 2 | Index of the selected candidate |
| out_first | output | 1 | Marks the first sample of the output symbol |
| out_last | output | 1 | Marks the last sample of the output symbol |

## Verification
The bound checker watches the handshake on every cycle:

- input and output never open together;
- the output holds still under back-pressure;
- the side index stays fixed across a symbol and the first-sample flag leads each symbol;
- the 65-cycle gap from the last input to the first output, counted by the checker;
- the return to loading right after the last output.

Whether each candidate's arithmetic is right, and whether the winner is truly the lowest peak with ties going to the lower index, can only be shown by the bench. It compares streamed samples against an independent model on directed symbols (all zero, constant, a single impulse, full-scale negative) and on random symbols searched so that each of the four candidates wins at least once.

// File: rtl/slm_pkg.sv
package slm_pkg;

    localparam int N_CAND = 4;   // unrotated symbol plus three rotations
    localparam int N_TAP  = 4;   // period of the rotation patterns
    localparam int SIDE_W = 2;

    typedef enum logic [1:0] {
        PH_LOAD,
        PH_EVAL,
        PH_PICK,
        PH_SEND
    } phase_e;

    // Weight of one quarter-symbol tap: (re + j*im) / 2
    typedef struct packed {
        logic signed [2:0] re;
        logic signed [2:0] im;
    } coef_t;

    // Tap weights = inverse 4-point DFT of the rotation pattern, times 2
    function automatic coef_t tap_coef(input int cand, input int tap);
        coef_t k;
        k.re = 3'sd0;
        k.im = 3'sd0;
        case (cand)
            0: begin
                if (tap == 0) k.re = 3'sd2;
            end
            1: begin
                if (tap == 0) begin
                    k.re = 3'sd1;
                    k.im = 3'sd1;
                end else if (tap == 2) begin
                    k.re = 3'sd1;
                    k.im = -3'sd1;
                end
            end
            2: begin
                k.re = (tap == 1) ? -3'sd1 : 3'sd1;
            end
            3: begin
                case (tap)
                    0:       k.im = 3'sd1;
                    2:       k.im = -3'sd1;
                    default: k.re = 3'sd1;
                endcase
            end
            default: ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/slm_sample_buf.sv
module slm_sample_buf
    import slm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int NPTS = 64
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [$clog2(NPTS)-1:0] addr,
    input  logic signed [DW-1:0] wr_re,
    input  logic signed [DW-1:0] wr_im,
    output logic signed [DW-1:0] tap_re [N_TAP],
    output logic signed [DW-1:0] tap_im [N_TAP]
);
    localparam int AW     = $clog2(NPTS);
    localparam int STRIDE = NPTS / N_TAP;

    logic signed [DW-1:0] mem_re [NPTS];
    logic signed [DW-1:0] mem_im [NPTS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_re[addr] <= wr_re;
            mem_im[addr] <= wr_im;
        end
    end

    // Tap m reads the sample m quarter-symbols behind addr, wrapping cyclically
    for (genvar m = 0; m < N_TAP; m++) begin : g_tap
        localparam logic [AW-1:0] OFS = AW'(m * STRIDE);
        logic [AW-1:0] raddr;
        assign raddr     = addr - OFS;
        assign tap_re[m] = mem_re[raddr];
        assign tap_im[m] = mem_im[raddr];
    end

endmodule

// File: rtl/slm_rotator.sv
module slm_rotator
    import slm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CAND = 0
) (
    input  logic signed [DW-1:0] tap_re [N_TAP],
    input  logic signed [DW-1:0] tap_im [N_TAP],
    output logic signed [DW+1:0] rot_re,
    output logic signed [DW+1:0] rot_im
);
    localparam int SW = DW + 3;   // exact width of the doubled sum

    // Multiplier-free weighting: zero, pass, negate, or doubled
    function automatic logic signed [SW-1:0] weigh(input logic signed [SW-1:0] v,
                                                   input logic signed [2:0]    k);
        case (k)
            3'sd1:   return v;
            -3'sd1:  return -v;
            3'sd2:   return v <<< 1;
            -3'sd2:  return -(v <<< 1);
            default: return '0;
        endcase
    endfunction

    logic signed [SW-1:0] acc_re, acc_im;

    always_comb begin
        acc_re = '0;
        acc_im = '0;
        for (int m = 0; m < N_TAP; m++) begin
            acc_re = acc_re
                   + weigh({{3{tap_re[m][DW-1]}}, tap_re[m]}, tap_coef(CAND, m).re)
                   - weigh({{3{tap_im[m][DW-1]}}, tap_im[m]}, tap_coef(CAND, m).im);
            acc_im = acc_im
                   + weigh({{3{tap_im[m][DW-1]}}, tap_im[m]}, tap_coef(CAND, m).re)
                   + weigh({{3{tap_re[m][DW-1]}}, tap_re[m]}, tap_coef(CAND, m).im);
        end
    end

    // Dropping the LSB is an arithmetic halving (floor)
    assign rot_re = acc_re[SW-1:1];
    assign rot_im = acc_im[SW-1:1];

endmodule

// File: rtl/slm_peak_select.sv
module slm_peak_select
    import slm_pkg::*;
#(
    parameter int OW = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 clear,
    input  logic signed [OW-1:0] c_re [N_CAND],
    input  logic signed [OW-1:0] c_im [N_CAND],
    output logic [SIDE_W-1:0]    best
);
    localparam int PW = 2 * OW;

    logic [PW-1:0] pw   [N_CAND];
    logic [PW-1:0] peak [N_CAND];

    for (genvar c = 0; c < N_CAND; c++) begin : g_pow
        logic signed [PW-1:0] er, ei;
        assign er    = {{OW{c_re[c][OW-1]}}, c_re[c]};
        assign ei    = {{OW{c_im[c][OW-1]}}, c_im[c]};
        assign pw[c] = er * er + ei * ei;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CAND; c++) peak[c] <= '0;
        end else if (en) begin
            for (int c = 0; c < N_CAND; c++) begin
                if (clear || (pw[c] > peak[c])) peak[c] <= pw[c];
            end
        end
    end

    // Strict compare keeps the lower index on ties
    always_comb begin
        best = '0;
        for (int c = 1; c < N_CAND; c++) begin
            if (peak[c] < peak[best]) best = SIDE_W'(c);
        end
    end

endmodule

// File: rtl/slm_selector.sv
module slm_selector
    import slm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int NPTS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [DW+1:0] out_re,
    output logic signed [DW+1:0] out_im,
    output logic [SIDE_W-1:0]    out_side,
    output logic                 out_first,
    output logic                 out_last
);
    localparam int            AW   = $clog2(NPTS);
    localparam int            OW   = DW + 2;
    localparam logic [AW-1:0] LAST = AW'(NPTS - 1);

    phase_e              phase;
    logic [AW-1:0]       idx;
    logic [SIDE_W-1:0]   sel;
    logic [SIDE_W-1:0]   best;

    logic signed [DW-1:0] tap_re  [N_TAP];
    logic signed [DW-1:0] tap_im  [N_TAP];
    logic signed [OW-1:0] cand_re [N_CAND];
    logic signed [OW-1:0] cand_im [N_CAND];

    assign in_ready  = (phase == PH_LOAD);
    assign out_valid = (phase == PH_SEND);

    slm_sample_buf #(.DW(DW), .NPTS(NPTS)) u_buf (
        .clk    (clk),
        .wr_en  (in_valid && in_ready),
        .addr   (idx),
        .wr_re  (in_re),
        .wr_im  (in_im),
        .tap_re (tap_re),
        .tap_im (tap_im)
    );

    for (genvar c = 0; c < N_CAND; c++) begin : g_cand
        slm_rotator #(.DW(DW), .CAND(c)) u_rot (
            .tap_re (tap_re),
            .tap_im (tap_im),
            .rot_re (cand_re[c]),
            .rot_im (cand_im[c])
        );
    end

    slm_peak_select #(.OW(OW)) u_peak (
        .clk   (clk),
        .rst   (rst),
        .en    (phase == PH_EVAL),
        .clear (idx == '0),
        .c_re  (cand_re),
        .c_im  (cand_im),
        .best  (best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LOAD;
            idx   <= '0;
            sel   <= '0;
        end else begin
            case (phase)
                PH_LOAD: if (in_valid) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) phase <= PH_EVAL;
                end
                PH_EVAL: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) phase <= PH_PICK;
                end
                PH_PICK: begin
                    sel   <= best;
                    phase <= PH_SEND;
                end
                PH_SEND: if (out_ready) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) phase <= PH_LOAD;
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    assign out_re    = cand_re[sel];
    assign out_im    = cand_im[sel];
    assign out_side  = sel;
    assign out_first = out_valid && (idx == '0);
    assign out_last  = out_valid && (idx == LAST);

endmodule

// File: rtl/slm_selector_chk.sv
module slm_selector_chk #(
    parameter int OW   = 14,
    parameter int NPTS = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic signed [OW-1:0] out_re,
    input logic signed [OW-1:0] out_im,
    input logic [1:0]           out_side,
    input logic                 out_first,
    input logic                 out_last
);
    localparam int CW     = $clog2(NPTS) + 1;
    localparam int LAT_HI = NPTS + 2;
    localparam int LW     = $clog2(LAT_HI + 1) + 1;

    logic [CW-1:0] in_cnt;
    logic [LW-1:0] lat;

    // Counts the load and times the gap to the first output
    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt <= '0;
            lat    <= '0;
        end else begin
            if (lat == LW'(LAT_HI))      lat <= '0;
            else if (lat != '0)          lat <= lat + 1'b1;
            if (in_valid && in_ready) begin
                if (in_cnt == CW'(NPTS - 1)) begin
                    in_cnt <= '0;
                    lat    <= LW'(1);
                end else begin
                    in_cnt <= in_cnt + 1'b1;
                end
            end
        end
    end

    a_r11_reset_state: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    a_r1_one_side: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_re) && $stable(out_im) &&
         $stable(out_side) && $stable(out_first) && $stable(out_last)));

    a_r7_side_fixed: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (out_valid && $stable(out_side)));

    a_r7_first_leads: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_first);

    a_r7_marks: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_first, out_last}));

    a_r10_reload: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        ((lat != '0) && (lat < LW'(LAT_HI))) |-> !out_valid);

    a_r8_rise: assert property (@(posedge clk) disable iff (rst)
        (lat == LW'(LAT_HI)) |-> out_valid);

endmodule

bind slm_selector slm_selector_chk #(.OW(OW), .NPTS(NPTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_side  (out_side),
    .out_first (out_first),
    .out_last  (out_last)
);

// File: tb/slm_selector_test.sv
`timescale 1ns/100ps
module slm_selector_test;
    localparam int DW   = 12;
    localparam int NPTS = 64;
    localparam int OW   = DW + 2;
    localparam int QTR  = NPTS / 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic signed [OW-1:0] out_re, out_im;
    logic [1:0]           out_side;
    logic                 out_first, out_last;

    always #2.5 clk = ~clk;

    slm_selector #(.DW(DW), .NPTS(NPTS)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
        .out_side(out_side), .out_first(out_first), .out_last(out_last)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int sym_re [NPTS];
    int sym_im [NPTS];
    int exp_re [NPTS];
    int exp_im [NPTS];
    int exp_side;

    // Tap weights times 2, written from R2..R5: weight = (wr + j*wi)/2
    int wr [4][4] = '{'{2, 0, 0, 0}, '{1, 0, 1, 0}, '{1, -1, 1, 1}, '{0, 1, 0, 1}};
    int wi [4][4] = '{'{0, 0, 0, 0}, '{1, 0, -1, 0}, '{0, 0, 0, 0}, '{1, 0, -1, 0}};
    string ctag [4] = '{"R2", "R3", "R4", "R5"};

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Independent model: all candidates, peaks, winner (R2..R6)
    function automatic int model();
        int cre [4][NPTS];
        int cim [4][NPTS];
        int peak [4];
        int win;
        for (int c = 0; c < 4; c++) begin
            peak[c] = 0;
            for (int n = 0; n < NPTS; n++) begin
                int sr = 0;
                int si = 0;
                for (int m = 0; m < 4; m++) begin
                    int k = (n - m * QTR + NPTS) % NPTS;
                    sr += wr[c][m] * sym_re[k] - wi[c][m] * sym_im[k];
                    si += wr[c][m] * sym_im[k] + wi[c][m] * sym_re[k];
                end
                cre[c][n] = sr >>> 1;
                cim[c][n] = si >>> 1;
                if (cre[c][n] * cre[c][n] + cim[c][n] * cim[c][n] > peak[c])
                    peak[c] = cre[c][n] * cre[c][n] + cim[c][n] * cim[c][n];
            end
        end
        win = 0;
        for (int c = 1; c < 4; c++) if (peak[c] < peak[win]) win = c;
        for (int n = 0; n < NPTS; n++) begin
            exp_re[n] = cre[win][n];
            exp_im[n] = cim[win][n];
        end
        return win;
    endfunction

    task automatic fill_random(input int amp);
        for (int n = 0; n < NPTS; n++) begin
            sym_re[n] = int'($urandom_range(2 * amp)) - amp;
            sym_im[n] = int'($urandom_range(2 * amp)) - amp;
        end
    endtask

    task automatic run_symbol(input int bp_pct);
        int n;
        exp_side = model();
        // Load (R1)
        for (int i = 0; i < NPTS; i++) begin
            @(negedge clk);
            while (int'($urandom_range(99)) < bp_pct / 2) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            if (i == 0) chk("R1 ready in load", int'(in_ready), 1);
            in_valid = 1'b1;
            in_re    = DW'(sym_re[i]);
            in_im    = DW'(sym_im[i]);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        // Latency (R8) and closed input (R1)
        repeat (NPTS) @(posedge clk);
        @(negedge clk);
        chk("R8 no output yet", int'(out_valid), 0);
        chk("R1 ready low after load", int'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 output rises", int'(out_valid), 1);
        // Replay with back-pressure (R7, R9)
        n = 0;
        while (n < NPTS) begin
            out_ready = (int'($urandom_range(99)) >= bp_pct);
            if (out_ready && out_valid) begin
                chk(ctag[exp_side], int'(out_re), exp_re[n]);
                chk(ctag[exp_side], int'(out_im), exp_im[n]);
                if (n == 0) begin
                    chk("R6 selected index", int'(out_side), exp_side);
                    chk("R7 first flag", int'(out_first), 1);
                end
                if (n == NPTS - 1) begin
                    chk("R7 side held", int'(out_side), exp_side);
                    chk("R7 last flag", int'(out_last), 1);
                end else begin
                    chk("R7 last flag low", int'(out_last), 0);
                end
                n++;
            end else if (!out_valid) begin
                chk("R9 valid dropped early", int'(out_valid), 1);
                n = NPTS;
            end
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk("R10 ready after replay", int'(in_ready), 1);
        chk("R10 valid after replay", int'(out_valid), 0);
    endtask

    task automatic run_target(input int want, input int bp_pct);
        for (int t = 0; t < 300; t++) begin
            fill_random(2047);
            if (model() == want) break;
        end
        run_symbol(bp_pct);
    endtask

    initial begin
        void'($urandom(32'd4099));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 ready in reset", int'(in_ready), 1);
        chk("R11 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ready after reset", int'(in_ready), 1);
        chk("R11 valid after reset", int'(out_valid), 0);

        // All zero: every peak ties, index 0 wins (R6, R2)
        for (int n = 0; n < NPTS; n++) begin sym_re[n] = 0; sym_im[n] = 0; end
        run_symbol(0);
        // Constant complex value: all candidates equal, index 0 wins (R6)
        for (int n = 0; n < NPTS; n++) begin sym_re[n] = 1000; sym_im[n] = -700; end
        run_symbol(30);
        // Single impulse: candidates 2 and 3 tie, 2 wins (R6, R4)
        for (int n = 0; n < NPTS; n++) begin sym_re[n] = 0; sym_im[n] = 0; end
        sym_re[5] = 1000;
        run_symbol(50);
        // Full-scale negative: widest sums, no overflow
        for (int n = 0; n < NPTS; n++) begin sym_re[n] = -2048; sym_im[n] = -2048; end
        run_symbol(20);
        // Random symbols aimed at each winner (R3, R5 and the rest)
        for (int c = 0; c < 4; c++) run_target(c, 40);
        run_target(1, 0);
        run_target(3, 70);
        fill_random(300);
        run_symbol(10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule